// File: doc/BRIEF.md
# Partial Line Write Merger

This block sits between a processor-side request stream and a memory controller. It turns writes that cover only part of a cache line into complete line writes. When a partial write arrives, the block fetches the current contents of the line, takes the new bytes wherever the byte enables are set and keeps the old bytes elsewhere, and then writes the whole merged line back. A write that covers the whole line needs no merge and goes straight to the memory write port in the same cycle.

The engine handles one partial write at a time. The requester learns that its partial write is done only when the merged line is accepted by memory, through a one-cycle `pw_posted` pulse. While a merge is under way, the block watches every processor access. Any access to the line being merged, a second partial write to any line, and any full-line write that would collide with the merged write on the write port are all refused with a same-cycle `req_retry`. The requester must present such an access again later. Other traffic carries on while the merge runs.

Top module: `line_rmw_merger`

## Requirements
- R1: While reset is held and after it is released with no request, `mem_rd_valid`, `mem_wr_valid`, `req_retry` and `pw_posted` are all 0.
- R2: A partial write (`req_valid`=1, `req_write`=1, `req_full`=0) accepted while idle makes `mem_rd_valid` rise on the next cycle with `mem_rd_addr` equal to the request line address. Both stay constant until the cycle in which `mem_rd_ready` is 1, and `mem_rd_valid` is 0 on the cycle after that.
- R3: The merged line satisfies the following for each byte i (bits 8i+7 down to 8i). It equals the request data byte when `req_be[i]`=1, and the byte returned on `mem_rsp_data` when `req_be[i]`=0.
- R4: `mem_wr_valid` rises on the cycle after `mem_rsp_valid`. It carries the merged line and the held address. Address and data stay unchanged until `mem_wr_ready` is 1. `pw_posted` is 1 exactly in that handshake cycle, and the port is idle on the next cycle.
- R5: A partial write that is not refused on other grounds is accepted while idle. A partial write arriving while a merge is in progress gets `req_retry`=1 whatever its address.
- R6: While a merge is in progress, any access (read or write) whose line address equals the held address gets `req_retry`=1. A full-line write to that line does not reach the write port.
- R7: During the read or wait phase of a merge, reads and full-line writes to other lines are not retried.
- R8: A full-line write (`req_full`=1) that is not refused drives `mem_wr_valid`=1 with its own address and data in the same cycle. `req_retry` equals the inverse of `mem_wr_ready` in that cycle.
- R9: While the merged line is waiting on the write port, a full-line write to another line gets `req_retry`=1, and the port keeps showing the merged line.
- R10: A `mem_rsp_valid` pulse while no read is outstanding has no effect. No write is issued, and the next merge uses only the data returned for its own read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | 1 = write covers the whole line |
| req_addr | input | AW | Line address of the access |
| req_data | input | 8*LINE_BYTES | Write data for the line |
| req_be | input | LINE_BYTES | Byte enables, bit i selects byte i |
| req_retry | output | 1 | Access refused this cycle, present again later |
| pw_posted | output | 1 | The held partial write has completed |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | AW | Line address to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8*LINE_BYTES | Returned line contents |
| mem_wr_valid | output | 1 | Line write request |
| mem_wr_ready | input | 1 | Memory takes the write |
| mem_wr_addr | output | AW | Line address to write |
| mem_wr_data | output | 8*LINE_BYTES | Full line to write |

## Verification
On every cycle, the assertions enforce four things. A partial write or a same-line access is refused while busy. The read and merged-write requests hold steady until memory takes them. A full write never takes the port from the merged line. The completion pulse appears only together with a write handshake. Only the bench's scenarios can show that the merged bytes are right for a given enable pattern, that stray responses leave later merges untouched, and that other-line reads and full writes flow through during the read and wait phases.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    // Merge engine phases; the encoding order follows the engine's sequence.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_REQ  = 2'd1,
        ST_RD_WAIT = 2'd2,
        ST_WR_REQ  = 2'd3
    } rmw_state_e;

endpackage

// File: rtl/rmw_byte_merge.sv
module rmw_byte_merge #(
    parameter int LINE_BYTES = 64,
    localparam int LW = LINE_BYTES * 8
) (
    input  logic [LW-1:0]         old_line,
    input  logic [LW-1:0]         new_line,
    input  logic [LINE_BYTES-1:0] byte_en,
    output logic [LW-1:0]         merged_line
);

    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_byte
        assign merged_line[8*g +: 8] = byte_en[g] ? new_line[8*g +: 8]
                                                  : old_line[8*g +: 8];
    end

endmodule

// File: rtl/rmw_route.sv
module rmw_route #(
    parameter int AW = 32
) (
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_full,
    input  logic [AW-1:0] req_addr,
    input  logic          busy,
    input  logic          wr_phase,
    input  logic [AW-1:0] held_addr,
    input  logic          mem_wr_ready,
    output logic          req_retry,
    output logic          pw_take,
    output logic          fw_pass
);

    logic line_hit;
    logic is_partial;
    logic is_full;

    always_comb begin
        line_hit   = busy && (req_addr == held_addr);
        is_partial = req_valid && req_write && !req_full;
        is_full    = req_valid && req_write && req_full;

        pw_take    = is_partial && !busy;
        fw_pass    = is_full && !line_hit && !wr_phase;

        req_retry  = 1'b0;
        if (req_valid) begin
            if (line_hit)                  req_retry = 1'b1;
            else if (is_partial && busy)   req_retry = 1'b1;
            else if (is_full && wr_phase)  req_retry = 1'b1;
            else if (fw_pass)              req_retry = !mem_wr_ready;
        end
    end

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import rmw_pkg::*;
#(
    parameter int AW = 32,
    parameter int LINE_BYTES = 64,
    localparam int LW = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pw_take,
    input  logic [AW-1:0]         req_addr,
    input  logic [LW-1:0]         req_data,
    input  logic [LINE_BYTES-1:0] req_be,
    input  logic                  mem_rd_ready,
    input  logic                  mem_rsp_valid,
    input  logic [LW-1:0]         merged_line,
    input  logic                  mem_wr_ready,
    output rmw_state_e            state,
    output logic [AW-1:0]         held_addr,
    output logic [LW-1:0]         held_data,
    output logic [LINE_BYTES-1:0] held_be
);

    typedef struct packed {
        rmw_state_e            st;
        logic [AW-1:0]         addr;
        logic [LW-1:0]         data;  // new bytes, then the merged line
        logic [LINE_BYTES-1:0] be;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        case (c_q.st)
            ST_IDLE: begin
                if (pw_take) begin
                    c_d.st   = ST_RD_REQ;
                    c_d.addr = req_addr;
                    c_d.data = req_data;
                    c_d.be   = req_be;
                end
            end
            ST_RD_REQ: begin
                if (mem_rd_ready) c_d.st = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    c_d.st   = ST_WR_REQ;
                    c_d.data = merged_line;
                end
            end
            ST_WR_REQ: begin
                if (mem_wr_ready) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign state     = c_q.st;
    assign held_addr = c_q.addr;
    assign held_data = c_q.data;
    assign held_be   = c_q.be;

endmodule

// File: rtl/line_rmw_merger.sv
module line_rmw_merger
    import rmw_pkg::*;
#(
    parameter int AW = 32,
    parameter int LINE_BYTES = 64,
    localparam int LW = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_full,
    input  logic [AW-1:0]         req_addr,
    input  logic [LW-1:0]         req_data,
    input  logic [LINE_BYTES-1:0] req_be,
    output logic                  req_retry,
    output logic                  pw_posted,
    output logic                  mem_rd_valid,
    input  logic                  mem_rd_ready,
    output logic [AW-1:0]         mem_rd_addr,
    input  logic                  mem_rsp_valid,
    input  logic [LW-1:0]         mem_rsp_data,
    output logic                  mem_wr_valid,
    input  logic                  mem_wr_ready,
    output logic [AW-1:0]         mem_wr_addr,
    output logic [LW-1:0]         mem_wr_data
);

    rmw_state_e            state;
    logic [AW-1:0]         held_addr;
    logic [LW-1:0]         held_data;
    logic [LINE_BYTES-1:0] held_be;
    logic [LW-1:0]         merged_line;
    logic                  busy;
    logic                  wr_phase;
    logic                  pw_take;
    logic                  fw_pass;

    assign busy     = (state != ST_IDLE);
    assign wr_phase = (state == ST_WR_REQ);

    rmw_route #(.AW(AW)) i_route (
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_full     (req_full),
        .req_addr     (req_addr),
        .busy         (busy),
        .wr_phase     (wr_phase),
        .held_addr    (held_addr),
        .mem_wr_ready (mem_wr_ready),
        .req_retry    (req_retry),
        .pw_take      (pw_take),
        .fw_pass      (fw_pass)
    );

    rmw_byte_merge #(.LINE_BYTES(LINE_BYTES)) i_merge (
        .old_line    (mem_rsp_data),
        .new_line    (held_data),
        .byte_en     (held_be),
        .merged_line (merged_line)
    );

    rmw_ctrl #(.AW(AW), .LINE_BYTES(LINE_BYTES)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pw_take       (pw_take),
        .req_addr      (req_addr),
        .req_data      (req_data),
        .req_be        (req_be),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .merged_line   (merged_line),
        .mem_wr_ready  (mem_wr_ready),
        .state         (state),
        .held_addr     (held_addr),
        .held_data     (held_data),
        .held_be       (held_be)
    );

    always_comb begin
        mem_rd_valid = (state == ST_RD_REQ);
        mem_rd_addr  = held_addr;
        mem_wr_valid = wr_phase || fw_pass;
        mem_wr_addr  = wr_phase ? held_addr : req_addr;
        mem_wr_data  = wr_phase ? held_data : req_data;
        pw_posted    = wr_phase && mem_wr_ready;
    end

endmodule

// File: rtl/rmw_merge_checker.sv
module rmw_merge_checker #(
    parameter int AW = 32,
    parameter int LW = 512
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_full,
    input logic [AW-1:0] req_addr,
    input logic          req_retry,
    input logic          pw_posted,
    input logic          mem_rd_valid,
    input logic          mem_rd_ready,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_wr_valid,
    input logic          mem_wr_ready,
    input logic [LW-1:0] mem_wr_data,
    input logic          busy,
    input logic          wr_phase,
    input logic [AW-1:0] held_addr
);

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R2

    AST_RD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> busy && !mem_wr_valid || busy); // R2

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase && !mem_wr_ready |=> wr_phase && mem_wr_valid && $stable(mem_wr_data)); // R4

    AST_POST_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        pw_posted |-> mem_wr_valid && mem_wr_ready); // R4

    AST_POST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pw_posted |=> !pw_posted && !busy); // R4

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && !req_full && busy |-> req_retry); // R5

    AST_LINE_HIT_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && busy && (req_addr == held_addr) |-> req_retry); // R6

    AST_PORT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_full && wr_phase |-> req_retry); // R9

endmodule

bind line_rmw_merger rmw_merge_checker #(.AW(AW), .LW(LINE_BYTES * 8)) i_rmw_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_full     (req_full),
    .req_addr     (req_addr),
    .req_retry    (req_retry),
    .pw_posted    (pw_posted),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_data  (mem_wr_data),
    .busy         (busy),
    .wr_phase     (wr_phase),
    .held_addr    (held_addr)
);

// File: tb/test_line_rmw_merger.sv
module test_line_rmw_merger;

    localparam int AW = 32;
    localparam int LB = 64;
    localparam int LW = LB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_full = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_data = '0;
    logic [LB-1:0] req_be = '0;
    logic          req_retry;
    logic          pw_posted;
    logic          mem_rd_valid;
    logic          mem_rd_ready = 1'b0;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [LW-1:0] mem_rsp_data = '0;
    logic          mem_wr_valid;
    logic          mem_wr_ready = 1'b0;
    logic [AW-1:0] mem_wr_addr;
    logic [LW-1:0] mem_wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    line_rmw_merger #(.AW(AW), .LINE_BYTES(LB)) i_line_rmw_merger (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_full(req_full),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .req_retry(req_retry), .pw_posted(pw_posted),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] rand_line();
        logic [LW-1:0] r;
        for (int i = 0; i < LW / 32; i++) r[32*i +: 32] = $urandom();
        return r;
    endfunction

    function automatic logic [LW-1:0] expect_merge(logic [LW-1:0] nd, logic [LW-1:0] od,
                                                   logic [LB-1:0] be);
        logic [LW-1:0] m;
        for (int i = 0; i < LB; i++) m[8*i +: 8] = be[i] ? nd[8*i +: 8] : od[8*i +: 8];
        return m;
    endfunction

    task automatic drive_req(input bit wr, input bit full, input logic [AW-1:0] a,
                             input logic [LW-1:0] d, input logic [LB-1:0] be);
        req_valid = 1'b1; req_write = wr; req_full = full;
        req_addr = a; req_data = d; req_be = be;
    endtask

    task automatic idle_req();
        req_valid = 1'b0; req_write = 1'b0; req_full = 1'b0;
    endtask

    task automatic run_partial(input logic [AW-1:0] a, input logic [LW-1:0] nd,
                               input logic [LB-1:0] be, input logic [LW-1:0] od,
                               input int rd_lat, input int wr_stall, input bit probe);
        logic [LW-1:0] exp_line;
        exp_line = expect_merge(nd, od, be);
        @(negedge clk);
        drive_req(1'b1, 1'b0, a, nd, be);
        #1 chk("R5 idle partial accepted", req_retry, 0);
        @(negedge clk);
        idle_req();
        #1 chk("R2 read raised", mem_rd_valid, 1);
        chk("R2 read address", mem_rd_addr, a);
        @(negedge clk);
        #1 chk("R2 read held while not ready", mem_rd_valid, 1);
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        #1 chk("R2 read dropped after handshake", mem_rd_valid, 0);
        if (probe) begin
            drive_req(1'b0, 1'b0, a, '0, '0);
            #1 chk("R6 same-line read retried", req_retry, 1);
            @(negedge clk);
            drive_req(1'b1, 1'b1, a, rand_line(), '1);
            mem_wr_ready = 1'b1;
            #1 chk("R6 same-line full write retried", req_retry, 1);
            chk("R6 same-line full write kept off port", mem_wr_valid, 0);
            @(negedge clk);
            mem_wr_ready = 1'b0;
            drive_req(1'b1, 1'b0, a ^ 32'h1, rand_line(), '1);
            #1 chk("R5 second partial retried", req_retry, 1);
            @(negedge clk);
            drive_req(1'b0, 1'b0, a ^ 32'h2, '0, '0);
            #1 chk("R7 other-line read allowed", req_retry, 0);
            @(negedge clk);
            drive_req(1'b1, 1'b1, a ^ 32'h4, nd ^ od, '1);
            mem_wr_ready = 1'b1;
            #1 chk("R7 other-line full write allowed", req_retry, 0);
            chk("R7 other-line full write address", mem_wr_addr, a ^ 32'h4);
            chk("R8 full write data during merge", mem_wr_data, nd ^ od);
            @(negedge clk);
            mem_wr_ready = 1'b0;
            idle_req();
        end
        for (int k = 0; k < rd_lat; k++) begin
            @(negedge clk);
            #1 chk("R4 no write before data", mem_wr_valid, 0);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data = od;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data = rand_line();
        #1 chk("R4 merged write raised", mem_wr_valid, 1);
        chk("R4 merged write address", mem_wr_addr, a);
        chk("R3 merged line", mem_wr_data, exp_line);
        chk("R4 no completion before handshake", pw_posted, 0);
        for (int k = 0; k < wr_stall; k++) begin
            drive_req(1'b1, 1'b1, a ^ 32'h8, rand_line(), '1);
            #1 chk("R9 full write refused in write phase", req_retry, 1);
            chk("R9 port keeps merged line", mem_wr_data, exp_line);
            @(negedge clk);
            idle_req();
            #1 chk("R4 merged write held", mem_wr_data, exp_line);
            chk("R4 no completion while stalled", pw_posted, 0);
        end
        mem_wr_ready = 1'b1;
        #1 chk("R4 completion pulse", pw_posted, 1);
        @(negedge clk);
        mem_wr_ready = 1'b0;
        #1 chk("R4 port idle after write", mem_wr_valid, 0);
        chk("R4 completion single cycle", pw_posted, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [LW-1:0] ln;
        logic [LW-1:0] od;
        logic [LB-1:0] be;
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        #1 chk("R1 reset read idle", mem_rd_valid, 0);
        chk("R1 reset write idle", mem_wr_valid, 0);
        chk("R1 reset retry low", req_retry, 0);
        chk("R1 reset completion low", pw_posted, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R1 idle after release", mem_rd_valid | mem_wr_valid | pw_posted, 0);

        // R8: full write in idle, first blocked by the port, then passed
        ln = rand_line();
        drive_req(1'b1, 1'b1, 32'h1000, ln, '1);
        mem_wr_ready = 1'b0;
        #1 chk("R8 full write retried when port not ready", req_retry, 1);
        chk("R8 full write presented", mem_wr_valid, 1);
        mem_wr_ready = 1'b1;
        #1 chk("R8 full write taken", req_retry, 0);
        chk("R8 full write address", mem_wr_addr, 32'h1000);
        chk("R8 full write data", mem_wr_data, ln);
        @(negedge clk);
        mem_wr_ready = 1'b0;
        drive_req(1'b0, 1'b0, 32'h1000, '0, '0);
        #1 chk("R7 idle read not retried", req_retry, 0);
        @(negedge clk);
        idle_req();

        // R10: stray response while idle
        mem_rsp_valid = 1'b1;
        mem_rsp_data = '1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        #1 chk("R10 stray response issues no write", mem_wr_valid, 0);
        chk("R10 stray response issues no read", mem_rd_valid, 0);

        // Directed corners: no enables, all enables, alternating with long stall
        run_partial(32'h2000, rand_line(), '0, rand_line(), 1, 1, 1'b1);
        run_partial(32'h2040, rand_line(), '1, rand_line(), 0, 0, 1'b0);
        run_partial(32'h2080, rand_line(), {32{2'b01}}, rand_line(), 3, 2, 1'b1);

        for (int it = 0; it < 24; it++) begin
            ln = rand_line();
            od = rand_line();
            be = {$urandom(), $urandom()};
            run_partial($urandom(), ln, be, od, $urandom_range(0, 3),
                        $urandom_range(0, 2), (it % 4) == 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule